// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the synchronous control front end of a word-wide parallel NOR flash. It watches bus write cycles on a 19-bit address and 16-bit data interface, where each cycle is framed by chip-enable and write-enable strobes sampled on the system clock. It recognises the protected command sequences that start an internal operation or change what reads return.

A word program, a sector erase, a block erase or a whole-array erase is reported as a single-clock start pulse. The pulse comes with the operation kind, the target address (already aligned to the sector or block it selects) and the last data word. The block also keeps the current read view: the normal array, the identification words or the query table. In the identification view it supplies the two identification words directly. The array itself, the duration of the internal operation and the electrical protection lie outside the block. The array side reports a running operation back through the `busy` input.

Top module: `nfc_cmd_decoder`

## Requirements
- R1: After synchronous reset the read view is array (`read_mode` = 0), `op_start` is low and `id_word` is 0.
- R2: A write cycle is open while `ce_n` = 0, `we_n` = 0 and `oe_n` = 1. It commits on the first clock where that condition is gone, with the address and data sampled on the last clock it held. With `oe_n` low or `ce_n` high, no cycle is committed.
- R3: The cycles AAh at 5555h, 55h at 2AAAh and A0h at 5555h, followed by one more cycle, raise `op_start` for exactly one clock, starting on the clock after the fourth commit. During that pulse `op_kind` = 1, `op_addr` is the fourth cycle's address and `op_data` is its data.
- R4: AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 30h at any address starts a sector erase. `op_kind` = 2, and `op_addr` is that address with bits 10..0 cleared.
- R5: The same six-cycle prefix ending in 50h starts a block erase. `op_kind` = 3, and `op_addr` is the address with bits 14..0 cleared.
- R6: The six-cycle prefix ending in 10h at 5555h starts a whole-array erase with `op_kind` = 4 and `op_addr` = 0. The same 10h written at any other address starts nothing.
- R7: The three-cycle unlock ending in 90h at 5555h selects the identification view (`read_mode` = 1). In that view `id_word` is 00BFh at address 0, 2781h at address 1 and 0 elsewhere. `id_word` is 0 in every other view.
- R8: The three-cycle unlock ending in 98h at 5555h selects the query view (`read_mode` = 2). Either a single F0h cycle outside a sequence, or the three-cycle unlock ending in F0h, returns to the array view.
- R9: Cycles committed while `busy` is high are ignored. They start nothing, do not change the read view (the exit command included) and do not advance a sequence.
- R10: A cycle that does not match the expected step of a sequence ends that sequence and selects the array view. The cycles that follow must start a new sequence from its first step.
- R11: Data bits 15..8 are ignored in every command cycle.
- R12: `op_start` is never high on two consecutive clocks. It is high only on the clock after a commit that completes a program or erase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; low blocks writes |
| addr | input | 19 | Word address |
| wdata | input | 16 | Write data word |
| busy | input | 1 | High while an internal program or erase runs |
| op_start | output | 1 | One-clock pulse starting an internal operation |
| op_kind | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 whole-array erase |
| op_addr | output | 19 | Target address, aligned for erases |
| op_data | output | 16 | Data word of the final cycle |
| read_mode | output | 2 | 0 array, 1 identification, 2 query |
| id_word | output | 16 | Identification word for the current address |

## Verification
The checker rebuilds the commit instant from the strobe pins alone. It therefore assumes each strobe pulse spans at least one clock edge and that `oe_n` stays high for the whole pulse of an intended write. The bench holds every write open for two clocks and releases the strobes together. It keeps address and data steady over the pulse, and it changes `busy` only while no write is open. All this keeps the timing of commits and start pulses unambiguous.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int unsigned ADDR_W = 19;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned CMD_W  = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CMD_W-1:0]  cmd_t;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PROG = 3'd1,
        OP_SECT = 3'd2,
        OP_BLK  = 3'd3,
        OP_CHIP = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_ID    = 2'd1,
        RM_CFI   = 2'd2
    } rmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3
    } seq_e;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } bus_cyc_t;

    localparam addr_t KEY_ADDR_A = addr_t'(19'h05555);
    localparam addr_t KEY_ADDR_B = addr_t'(19'h02AAA);

    localparam cmd_t KEY_A     = 8'hAA;
    localparam cmd_t KEY_B     = 8'h55;
    localparam cmd_t C_PROG    = 8'hA0;
    localparam cmd_t C_ERASE   = 8'h80;
    localparam cmd_t C_SECT    = 8'h30;
    localparam cmd_t C_BLK     = 8'h50;
    localparam cmd_t C_CHIP    = 8'h10;
    localparam cmd_t C_ID      = 8'h90;
    localparam cmd_t C_QUERY   = 8'h98;
    localparam cmd_t C_LEAVE   = 8'hF0;

    function automatic logic hits(bus_cyc_t c, addr_t a, cmd_t k);
        return (c.addr == a) && (c.data[CMD_W-1:0] == k);
    endfunction

    function automatic addr_t clear_low(addr_t a, int unsigned n);
        addr_t m;
        m = '1;
        m = m << n;
        return a & m;
    endfunction

endpackage

// File: rtl/nfc_bus_capture.sv
module nfc_bus_capture
    import nfc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ce_n,
    input  logic     we_n,
    input  logic     oe_n,
    input  addr_t    addr,
    input  data_t    wdata,
    output logic     cyc_valid,
    output bus_cyc_t cyc
);

    logic     strobe;
    logic     strobe_q;
    bus_cyc_t hold_q;

    assign strobe = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            hold_q   <= '0;
        end else begin
            strobe_q <= strobe;
            if (strobe) begin
                hold_q.addr <= addr;
                hold_q.data <= wdata;
            end
        end
    end

    assign cyc_valid = strobe_q && !strobe;
    assign cyc       = hold_q;

endmodule

// File: rtl/nfc_seq_fsm.sv
module nfc_seq_fsm
    import nfc_pkg::*;
#(
    parameter int unsigned SECT_LSB = 11,
    parameter int unsigned BLK_LSB  = 15
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     busy,
    input  logic     cyc_valid,
    input  bus_cyc_t cyc,
    output logic     op_start,
    output op_kind_e op_kind,
    output addr_t    op_addr,
    output data_t    op_data,
    output rmode_e   mode
);

    seq_e     st_q, st_n;
    rmode_e   mode_q, mode_n;
    logic     go_n;
    op_kind_e kind_q, kind_n;
    addr_t    oaddr_q, oaddr_n;
    data_t    odata_q, odata_n;
    logic     go_q;
    cmd_t     cmd;

    assign cmd = cyc.data[CMD_W-1:0];

    always_comb begin
        st_n    = st_q;
        mode_n  = mode_q;
        go_n    = 1'b0;
        kind_n  = kind_q;
        oaddr_n = oaddr_q;
        odata_n = odata_q;
        if (cyc_valid && !busy) begin
            case (st_q)
                SQ_IDLE: begin
                    if (hits(cyc, KEY_ADDR_A, KEY_A)) st_n = SQ_UNL1;
                    else if (cmd == C_LEAVE)          mode_n = RM_ARRAY;
                end
                SQ_UNL1: begin
                    if (hits(cyc, KEY_ADDR_B, KEY_B)) st_n = SQ_UNL2;
                    else begin st_n = SQ_IDLE; mode_n = RM_ARRAY; end
                end
                SQ_UNL2: begin
                    st_n = SQ_IDLE;
                    if (cyc.addr != KEY_ADDR_A) mode_n = RM_ARRAY;
                    else begin
                        case (cmd)
                            C_PROG:  st_n   = SQ_PROG;
                            C_ERASE: st_n   = SQ_ERA1;
                            C_ID:    mode_n = RM_ID;
                            C_QUERY: mode_n = RM_CFI;
                            default: mode_n = RM_ARRAY;
                        endcase
                    end
                end
                SQ_PROG: begin
                    st_n    = SQ_IDLE;
                    go_n    = 1'b1;
                    kind_n  = OP_PROG;
                    oaddr_n = cyc.addr;
                    odata_n = cyc.data;
                end
                SQ_ERA1: begin
                    if (hits(cyc, KEY_ADDR_A, KEY_A)) st_n = SQ_ERA2;
                    else begin st_n = SQ_IDLE; mode_n = RM_ARRAY; end
                end
                SQ_ERA2: begin
                    if (hits(cyc, KEY_ADDR_B, KEY_B)) st_n = SQ_ERA3;
                    else begin st_n = SQ_IDLE; mode_n = RM_ARRAY; end
                end
                SQ_ERA3: begin
                    st_n    = SQ_IDLE;
                    odata_n = cyc.data;
                    if (cmd == C_SECT) begin
                        go_n = 1'b1; kind_n = OP_SECT;
                        oaddr_n = clear_low(cyc.addr, SECT_LSB);
                    end else if (cmd == C_BLK) begin
                        go_n = 1'b1; kind_n = OP_BLK;
                        oaddr_n = clear_low(cyc.addr, BLK_LSB);
                    end else if (hits(cyc, KEY_ADDR_A, C_CHIP)) begin
                        go_n = 1'b1; kind_n = OP_CHIP;
                        oaddr_n = '0;
                    end else begin
                        mode_n = RM_ARRAY;
                    end
                end
                default: st_n = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            mode_q  <= RM_ARRAY;
            go_q    <= 1'b0;
            kind_q  <= OP_NONE;
            oaddr_q <= '0;
            odata_q <= '0;
        end else begin
            st_q    <= st_n;
            mode_q  <= mode_n;
            go_q    <= go_n;
            kind_q  <= kind_n;
            oaddr_q <= oaddr_n;
            odata_q <= odata_n;
        end
    end

    assign op_start = go_q;
    assign op_kind  = kind_q;
    assign op_addr  = oaddr_q;
    assign op_data  = odata_q;
    assign mode     = mode_q;

endmodule

// File: rtl/nfc_id_lookup.sv
module nfc_id_lookup
    import nfc_pkg::*;
#(
    parameter data_t MAKER_WORD  = 16'h00BF,
    parameter data_t DEVICE_WORD = 16'h2781
) (
    input  rmode_e mode,
    input  addr_t  addr,
    output data_t  id_word
);

    always_comb begin
        id_word = '0;
        if (mode == RM_ID) begin
            if (addr == addr_t'(0))      id_word = MAKER_WORD;
            else if (addr == addr_t'(1)) id_word = DEVICE_WORD;
        end
    end

endmodule

// File: rtl/nfc_cmd_decoder.sv
module nfc_cmd_decoder
    import nfc_pkg::*;
#(
    parameter int unsigned SECT_LSB = 11,
    parameter int unsigned BLK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic              op_start,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        read_mode,
    output logic [DATA_W-1:0] id_word
);

    logic     cyc_valid;
    bus_cyc_t cyc;
    op_kind_e kind;
    rmode_e   mode;

    nfc_bus_capture i_cap (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .wdata     (wdata),
        .cyc_valid (cyc_valid),
        .cyc       (cyc)
    );

    nfc_seq_fsm #(
        .SECT_LSB (SECT_LSB),
        .BLK_LSB  (BLK_LSB)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .cyc_valid (cyc_valid),
        .cyc       (cyc),
        .op_start  (op_start),
        .op_kind   (kind),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .mode      (mode)
    );

    nfc_id_lookup i_id (
        .mode    (mode),
        .addr    (addr),
        .id_word (id_word)
    );

    assign op_kind   = kind;
    assign read_mode = mode;

endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
    parameter int unsigned SECT_LSB = 11,
    parameter int unsigned BLK_LSB  = 15
) (
    input logic        clk,
    input logic        rst,
    input logic        ce_n,
    input logic        we_n,
    input logic        oe_n,
    input logic        busy,
    input logic        op_start,
    input logic [2:0]  op_kind,
    input logic [18:0] op_addr,
    input logic [1:0]  read_mode,
    input logic [15:0] id_word
);

    logic strb;
    logic strb_q;
    logic commit;

    assign strb = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) strb_q <= 1'b0;
        else     strb_q <= strb;
    end

    assign commit = strb_q && !strb;

    assert_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start);

    assert_start_after_commit_R12: assert property (@(posedge clk) disable iff (rst)
        !commit |=> !op_start);

    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (commit && busy) |=> (!op_start && $stable(read_mode)));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(read_mode));

    assert_sector_align_R4: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == 3'd2) |-> (op_addr[SECT_LSB-1:0] == '0));

    assert_block_align_R5: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == 3'd3) |-> (op_addr[BLK_LSB-1:0] == '0));

    assert_chip_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == 3'd4) |-> (op_addr == '0));

    assert_kind_known_R3: assert property (@(posedge clk) disable iff (rst)
        op_start |-> (op_kind inside {3'd1, 3'd2, 3'd3, 3'd4}));

    assert_mode_legal_R7: assert property (@(posedge clk) disable iff (rst)
        read_mode != 2'd3);

    assert_id_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (read_mode != 2'd1) |-> (id_word == 16'h0000));

endmodule

bind nfc_cmd_decoder nfc_checker #(
    .SECT_LSB (SECT_LSB),
    .BLK_LSB  (BLK_LSB)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .busy      (busy),
    .op_start  (op_start),
    .op_kind   (op_kind),
    .op_addr   (op_addr),
    .read_mode (read_mode),
    .id_word   (id_word)
);

// File: tb/test_nfc_cmd_decoder.sv
`timescale 1ns/1ps
module test_nfc_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [18:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        busy = 1'b0;
    logic        op_start;
    logic [2:0]  op_kind;
    logic [18:0] op_addr;
    logic [15:0] op_data;
    logic [1:0]  read_mode;
    logic [15:0] id_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0]  kind;
        logic [18:0] a;
        logic [15:0] d;
        string       tag;
    } exp_t;

    exp_t expq[$];

    always #10 clk = ~clk;

    nfc_cmd_decoder i_nfc_cmd_decoder (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .busy(busy),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .read_mode(read_mode), .id_word(id_word)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every start pulse must match the oldest expected item
    always @(negedge clk) begin
        if (!rst && op_start) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected start actual=%0h/%0h/%0h expected=none",
                         op_kind, op_addr, op_data);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (op_kind !== e.kind || op_addr !== e.a || op_data !== e.d) begin
                    fails++;
                    $display("FAIL %s actual=%0h/%0h/%0h expected=%0h/%0h/%0h",
                             e.tag, op_kind, op_addr, op_data, e.kind, e.a, e.d);
                end
            end
        end
    end

    task automatic push(logic [2:0] k, logic [18:0] a, logic [15:0] d, string tag);
        exp_t e;
        e.kind = k; e.a = a; e.d = d; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic wr_raw(logic [18:0] a, logic [15:0] d, logic ce_v, logic oe_v);
        @(negedge clk);
        addr = a; wdata = d; ce_n = ce_v; oe_n = oe_v; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [18:0] a, logic [15:0] d);
        wr_raw(a, d, 1'b0, 1'b1);
    endtask

    task automatic unlock3(logic [15:0] c);
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0055);
        wr(19'h05555, c);
    endtask

    task automatic erase6(logic [18:0] a, logic [15:0] c);
        unlock3(16'h0080);
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0055);
        wr(a, c);
    endtask

    task automatic peek_id(logic [18:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, {16'h0, id_word}, {16'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset read_mode", 32'(read_mode), 32'd0);
        check("R1 reset op_start", 32'(op_start), 32'd0);
        check("R1 reset id_word", 32'(id_word), 32'd0);

        // R3 programs with several patterns
        unlock3(16'h00A0); push(3'd1, 19'h12345, 16'hBEEF, "R3 program"); wr(19'h12345, 16'hBEEF);
        unlock3(16'h00A0); push(3'd1, 19'h00000, 16'h0000, "R3 program low"); wr(19'h00000, 16'h0000);
        unlock3(16'h00A0); push(3'd1, 19'h7FFFF, 16'hFFFF, "R3 program high"); wr(19'h7FFFF, 16'hFFFF);

        // R11 upper data bits ignored in command cycles
        wr(19'h05555, 16'h12AA);
        wr(19'h02AAA, 16'h3455);
        wr(19'h05555, 16'hC3A0);
        push(3'd1, 19'h0ABCD, 16'h5A5A, "R11 noisy upper byte");
        wr(19'h0ABCD, 16'h5A5A);

        // R4, R5, R6 erases
        push(3'd2, 19'h4A800, 16'h0030, "R4 sector erase");
        erase6(19'h4A9F3, 16'h0030);
        push(3'd3, 19'h48000, 16'h0050, "R5 block erase");
        erase6(19'h4A9F3, 16'h0050);
        push(3'd4, 19'h00000, 16'h0010, "R6 chip erase");
        erase6(19'h05555, 16'h0010);
        erase6(19'h01234, 16'h0010);
        check("R6 misplaced chip erase mode", 32'(read_mode), 32'd0);

        // R7 identification view
        unlock3(16'h0090);
        check("R7 id mode", 32'(read_mode), 32'd1);
        peek_id(19'h00000, 16'h00BF, "R7 maker word");
        peek_id(19'h00001, 16'h2781, "R7 device word");
        peek_id(19'h00002, 16'h0000, "R7 other address");
        wr(19'h00777, 16'h00F0);
        check("R8 single exit", 32'(read_mode), 32'd0);
        peek_id(19'h00000, 16'h0000, "R7 id off in array view");

        // R8 query view
        unlock3(16'h0098);
        check("R8 query mode", 32'(read_mode), 32'd2);
        unlock3(16'h00F0);
        check("R8 three-cycle exit", 32'(read_mode), 32'd0);
        unlock3(16'h0098);

        // R9 busy ignores commands
        @(negedge clk); busy = 1'b1;
        wr(19'h00000, 16'h00F0);
        check("R9 exit ignored while busy", 32'(read_mode), 32'd2);
        unlock3(16'h00A0);
        wr(19'h01000, 16'h5A5A);
        @(negedge clk); busy = 1'b0;
        wr(19'h02000, 16'h1111);
        check("R9 still query view", 32'(read_mode), 32'd2);
        wr(19'h00000, 16'h00F0);
        check("R9 exit after busy", 32'(read_mode), 32'd0);

        // R10 aborts
        unlock3(16'h0090);
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0011);
        check("R10 abort to array", 32'(read_mode), 32'd0);
        wr(19'h02AAA, 16'h0055);
        wr(19'h05555, 16'h00A0);
        wr(19'h03000, 16'h2222);
        erase6(19'h05555, 16'h0077);
        check("R10 erase abort mode", 32'(read_mode), 32'd0);

        // R2 blocked cycles, then a real one
        unlock3(16'h00A0);
        wr_raw(19'h06000, 16'hDEAD, 1'b0, 1'b0);
        wr_raw(19'h06000, 16'hDEAD, 1'b1, 1'b1);
        push(3'd1, 19'h06001, 16'hCAFE, "R2 blocked cycles skipped");
        wr(19'h06001, 16'hCAFE);

        repeat (4) @(negedge clk);
        check("R12 no pending start", 32'(expq.size()), 32'd0);
        check("R12 op_start idle", 32'(op_start), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule